// File: doc/BRIEF.md
# Configurable External Interrupt Controller

This block watches up to four external interrupt pins and turns their activity into one interrupt request per pin for a parent interrupt controller. Each pin is first brought into the clock domain by a two-flop synchroniser. Trigger logic then decides, for each cycle, whether the pin's programmed condition is met. The available conditions are a rising edge, a falling edge, either edge, a high level or a low level. A met condition sets a sticky pending bit for that pin.

All per-pin settings and the pending bits sit in one 32-bit word that is read and written through a simple register port. The word is split into six equal fields, and bit i of every field belongs to pin i. Software reads the pending bits and acknowledges a pin by writing a one to its clear bit. A per-pin enable bit gates the pending bit onto the request output. After reset every pin is active-low level sensitive and all outputs are gated off.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, rd_data reads 0x00F00000: all level-select bits are 1, which gives active-low level for every pin. All other bits read 0, and irq_out is 0.
- R2: Field k of the word occupies bits [k*4 +: 4], and bit i of a field belongs to pin i. The fields from k=0 upward are: polarity (0), pending (1), clear (2), enable (3), any-edge (4) and level-select (5). Bits 24 to 31 read 0.
- R3: With level-select 0, polarity 0 and any-edge 0, a low-to-high transition of the pin sets its pending bit. A high-to-low transition does not.
- R4: With level-select 0, polarity 1 and any-edge 0, a high-to-low transition sets the pending bit. A low-to-high transition does not.
- R5: With level-select 0 and any-edge 1, both transitions set the pending bit, whatever the polarity bit holds.
- R6: With level-select 1 and polarity 1, the pending bit is set in every cycle in which the synchronised pin is high.
- R7: With level-select 1 and polarity 0, the pending bit is set in every cycle in which the synchronised pin is low, and is not set while the pin is high.
- R8: A pin change shows in the pending bit on the third rising clock edge after it: two synchroniser stages, then the pending register. A pending bit stays set until it is cleared, even when the pin returns to idle, and even for a pulse only one cycle long.
- R9: Writing a 1 to a clear bit empties that pin's pending bit at the write edge, taking priority over a trigger in the same cycle. The clear field always reads 0. Writes to the pending field have no effect. A level that is still active sets the pending bit again on the following edge.
- R10: Pending bits are set even while the enable bit is 0. irq_out[i] is the pending bit of pin i ANDed with its enable bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 4 | Asynchronous external interrupt pins, idle high |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Register read value, combinational |
| irq_out | output | 4 | Per-pin requests toward the parent controller |

## Verification
Each trigger type gets its own pin and is driven in both directions. Rising-only and falling-only modes must react to exactly one of the two transitions, and any-edge mode must react to both even with its polarity bit set. In the level modes the pin is held active across a clear, which separates a live level (pending returns one cycle after the clear) from a latched edge (pending stays empty). A one-cycle low pulse in any-edge mode, a write of ones into the pending field, and a check of pending against the enable bit separate sticky latching, the read-only pending field and output gating from one another.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  // field index inside the shared control word; position is decoded by software
  localparam int unsigned FLD_POL   = 0;
  localparam int unsigned FLD_PEND  = 1;
  localparam int unsigned FLD_CLR   = 2;
  localparam int unsigned FLD_EN    = 3;
  localparam int unsigned FLD_ANY   = 4;
  localparam int unsigned FLD_LEVEL = 5;
  localparam int unsigned NUM_FLDS  = 6;

  typedef struct packed {
    logic level;  // 1: level sensitive
    logic pol;    // level: 1 high active; edge: 1 falling
    logic any;    // edge mode: both transitions
  } trig_cfg_t;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned WIDTH   = 4,
  parameter logic        IDLE_LV = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= {WIDTH{IDLE_LV}};
      stage2_q <= {WIDTH{IDLE_LV}};
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/ext_irq_pin.sv
module ext_irq_pin
  import ext_irq_pkg::*;
#(
  parameter logic IDLE_LV = 1'b1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      samp,
  input  trig_cfg_t cfg,
  input  logic      clr,
  output logic      pend
);
  logic prev_q;
  logic pend_q;
  logic pend_d;
  logic hit;

  always_comb begin
    if (cfg.level) begin
      hit = (samp == cfg.pol);
    end else if (cfg.any) begin
      hit = (samp != prev_q);
    end else if (cfg.pol) begin
      hit = prev_q & ~samp;
    end else begin
      hit = samp & ~prev_q;
    end
  end

  always_comb begin
    if (clr) begin
      pend_d = 1'b0;
    end else begin
      pend_d = pend_q | hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= IDLE_LV;
      pend_q <= 1'b0;
    end else begin
      prev_q <= samp;
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  // R9
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pend);

  // R8
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg.level && pend && !clr) |=> pend);

  // R6
  level_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.level && (samp == cfg.pol) && !clr) |=> pend);
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 4,
  parameter int unsigned FIELD_W  = 4,
  parameter int unsigned REG_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] ext_pin,
  input  logic                wr_en,
  input  logic [REG_W-1:0]    wr_data,
  output logic [REG_W-1:0]    rd_data,
  output logic [NUM_PINS-1:0] irq_out
);
  localparam int unsigned POL_LSB   = FLD_POL   * FIELD_W;
  localparam int unsigned PEND_LSB  = FLD_PEND  * FIELD_W;
  localparam int unsigned CLR_LSB   = FLD_CLR   * FIELD_W;
  localparam int unsigned EN_LSB    = FLD_EN    * FIELD_W;
  localparam int unsigned ANY_LSB   = FLD_ANY   * FIELD_W;
  localparam int unsigned LEVEL_LSB = FLD_LEVEL * FIELD_W;

  logic [NUM_PINS-1:0] pol_q,   pol_d;
  logic [NUM_PINS-1:0] en_q,    en_d;
  logic [NUM_PINS-1:0] any_q,   any_d;
  logic [NUM_PINS-1:0] level_q, level_d;
  logic [NUM_PINS-1:0] clr_pulse;
  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_PINS-1:0] pend;

  wire unused_wr_bits = ^wr_data;

  always_comb begin
    pol_d   = pol_q;
    en_d    = en_q;
    any_d   = any_q;
    level_d = level_q;
    if (wr_en) begin
      pol_d   = wr_data[POL_LSB   +: NUM_PINS];
      en_d    = wr_data[EN_LSB    +: NUM_PINS];
      any_d   = wr_data[ANY_LSB   +: NUM_PINS];
      level_d = wr_data[LEVEL_LSB +: NUM_PINS];
    end
  end

  assign clr_pulse = wr_en ? wr_data[CLR_LSB +: NUM_PINS] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q   <= '0;
      en_q    <= '0;
      any_q   <= '0;
      level_q <= '1;
    end else begin
      pol_q   <= pol_d;
      en_q    <= en_d;
      any_q   <= any_d;
      level_q <= level_d;
    end
  end

  ext_irq_sync #(
    .WIDTH   (NUM_PINS),
    .IDLE_LV (1'b1)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ext_pin),
    .sync_out (pin_sync)
  );

  for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
    trig_cfg_t cfg;
    assign cfg = '{level: level_q[g], pol: pol_q[g], any: any_q[g]};

    ext_irq_pin #(
      .IDLE_LV (1'b1)
    ) u_pin (
      .clk   (clk),
      .rst_n (rst_n),
      .samp  (pin_sync[g]),
      .cfg   (cfg),
      .clr   (clr_pulse[g]),
      .pend  (pend[g])
    );
  end

  always_comb begin
    rd_data = '0;
    rd_data[POL_LSB   +: NUM_PINS] = pol_q;
    rd_data[PEND_LSB  +: NUM_PINS] = pend;
    rd_data[EN_LSB    +: NUM_PINS] = en_q;
    rd_data[ANY_LSB   +: NUM_PINS] = any_q;
    rd_data[LEVEL_LSB +: NUM_PINS] = level_q;
  end

  assign irq_out = pend & en_q;

  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (rd_data[EN_LSB +: NUM_PINS] == $past(rd_data[EN_LSB +: NUM_PINS])));

  // R9
  clr_field_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[CLR_LSB +: NUM_PINS] == '0));
endmodule

// File: tb/test_ext_irq_ctrl.sv
module test_ext_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ext_pin = 4'hF;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [3:0]  irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [3:0] m_pol = 4'h0, m_en = 4'h0, m_any = 4'h0, m_lvl = 4'hF;

  ext_irq_ctrl i_ext_irq_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ext_pin (ext_pin),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .irq_out (irq_out)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input logic [3:0] clr, input logic [3:0] pend);
    return {8'h00, m_lvl, m_any, m_en, clr, pend, m_pol};
  endfunction

  // drive a write at a negedge, commit at posedge, return at next negedge
  task automatic wr(input logic [3:0] clr, input logic [3:0] pend);
    wr_data = word(clr, pend);
    wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [3:0] pend_rd();
    return rd_data[7:4];
  endfunction

  task automatic t_reset();
    chk("R1 reset word", rd_data, 32'h00F0_0000);
    chk("R1 reset irq_out", {28'h0, irq_out}, 32'h0);
  endtask

  task automatic t_active_low();
    ext_pin[0] = 1'b0;
    settle();
    chk("R7 low level sets pend", {31'h0, pend_rd()[0]}, 32'h1);
    chk("R10 pend while disabled, no irq", {28'h0, irq_out}, 32'h0);
    m_en = 4'b0001;
    wr(4'h0, 4'h0);
    chk("R10 enabled irq_out", {28'h0, irq_out}, 32'h1);
    chk("R2 enable field readback", {28'h0, rd_data[15:12]}, 32'h1);
    wr(4'b0001, 4'h0);
    chk("R9 clear empties pend", {31'h0, pend_rd()[0]}, 32'h0);
    chk("R9 clear field reads 0", {28'h0, rd_data[11:8]}, 32'h0);
    @(negedge clk);
    chk("R9 live level sets again", {31'h0, pend_rd()[0]}, 32'h1);
    ext_pin[0] = 1'b1;
    settle();
    wr(4'b0001, 4'h0);
    @(negedge clk);
    chk("R7 high pin does not set", {31'h0, pend_rd()[0]}, 32'h0);
  endtask

  task automatic t_rising();
    m_lvl[1] = 1'b0;
    wr(4'h0, 4'h0);
    ext_pin[1] = 1'b0;
    settle();
    chk("R3 falling ignored", {31'h0, pend_rd()[1]}, 32'h0);
    ext_pin[1] = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R8 not yet after two edges", {31'h0, pend_rd()[1]}, 32'h0);
    @(negedge clk);
    chk("R3 rising sets on third edge", {31'h0, pend_rd()[1]}, 32'h1);
    wr(4'b0010, 4'h0);
    settle();
    chk("R8 edge does not repeat while high", {31'h0, pend_rd()[1]}, 32'h0);
  endtask

  task automatic t_falling();
    m_lvl[2] = 1'b0;
    m_pol[2] = 1'b1;
    wr(4'h0, 4'h0);
    ext_pin[2] = 1'b0;
    settle();
    chk("R4 falling sets", {31'h0, pend_rd()[2]}, 32'h1);
    wr(4'b0100, 4'h0);
    ext_pin[2] = 1'b1;
    settle();
    chk("R4 rising ignored", {31'h0, pend_rd()[2]}, 32'h0);
  endtask

  task automatic t_any_edge();
    m_lvl[3] = 1'b0;
    m_any[3] = 1'b1;
    m_pol[3] = 1'b1;
    wr(4'h0, 4'h0);
    ext_pin[3] = 1'b0;
    settle();
    chk("R5 falling sets", {31'h0, pend_rd()[3]}, 32'h1);
    wr(4'b1000, 4'h0);
    ext_pin[3] = 1'b1;
    settle();
    chk("R5 rising sets despite polarity", {31'h0, pend_rd()[3]}, 32'h1);
    wr(4'b1000, 4'h0);
    settle();
    chk("R5 idle after clear", {31'h0, pend_rd()[3]}, 32'h0);
  endtask

  task automatic t_active_high();
    m_lvl[1] = 1'b1;
    m_pol[1] = 1'b1;
    wr(4'h0, 4'h0);
    settle();
    chk("R6 high level sets", {31'h0, pend_rd()[1]}, 32'h1);
    wr(4'b0010, 4'h0);
    chk("R9 clear wins over level", {31'h0, pend_rd()[1]}, 32'h0);
    @(negedge clk);
    chk("R6 level sets again", {31'h0, pend_rd()[1]}, 32'h1);
    ext_pin[1] = 1'b0;
    settle();
    wr(4'b0010, 4'h0);
    settle();
    chk("R6 low pin does not set", {31'h0, pend_rd()[1]}, 32'h0);
  endtask

  task automatic t_pend_readonly();
    chk("R9 all pend empty before", {28'h0, pend_rd()}, 32'h0);
    wr(4'h0, 4'hF);
    chk("R9 pend write ignored", {28'h0, pend_rd()}, 32'h0);
    @(negedge clk);
    chk("R9 pend write ignored later", {28'h0, pend_rd()}, 32'h0);
  endtask

  task automatic t_pulse();
    ext_pin[3] = 1'b0;
    @(negedge clk);
    ext_pin[3] = 1'b1;
    settle();
    chk("R8 short pulse latched", {28'h0, pend_rd()}, 32'h8);
    m_en = 4'hF;
    wr(4'h0, 4'h0);
    chk("R10 only pending pin requests", {28'h0, irq_out}, 32'h8);
    chk("R2 full word", rd_data, {8'h00, m_lvl, m_any, m_en, 4'h0, 4'h8, m_pol});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_active_low();
    t_rising();
    t_falling();
    t_any_edge();
    t_active_high();
    t_pend_readonly();
    t_pulse();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end
endmodule